// File: doc/BRIEF.md
# DMA Interrupt Pending and Enable Unit

This block gathers transfer events from sixteen DMA channels, eight in a normal group and eight in a dedicated group, and drives one level-sensitive interrupt line. Each channel raises a half-transfer event and an end-of-transfer event. Both events are captured as sticky bits in a 32-bit pending register. A 32-bit enable register with the same layout chooses which pending events may assert the interrupt. Software uses a small register bus to program the enable mask, to read both registers and to clear pending bits by writing ones.

Beside the interrupt line, a priority encoder reports the lowest-numbered pending end-of-transfer event as a group flag and a channel index. A service routine can then send the completion to the right channel with no software bit scan. The channel engines, arbitration and data movement sit in other blocks. This unit only sees their single-cycle event pulses.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the enable register and the pending register read as zero, `irqOut` is low and `endValid` is low.
- R2: Status bit layout: normal channel c uses bit 2c for half-transfer and bit 2c+1 for end-of-transfer. Dedicated channel c uses bit 16+2c for half-transfer and bit 17+2c for end-of-transfer.
- R3: A one-cycle event pulse sets its pending bit at the next clock edge. The bit stays set whatever the enable register holds.
- R4: A bus write to address 1 clears each pending bit whose data bit is one. Data bits that are zero leave their pending bits unchanged, so writing all ones clears every pending bit.
- R5: When an event and a write-one-to-clear of the same bit occur in the same cycle, the bit remains pending.
- R6: A bus write to address 0 loads the whole enable register. Writing zero disables every event.
- R7: `irqOut` is a register that holds the OR over all bits of pending AND enable. It follows that value one clock after the value changes. This includes the case where a bit is enabled after its event is already pending.
- R8: The encoder looks only at end-of-transfer pending bits. It selects the lowest-numbered set bit b and reports `endValid`=1, `endGroup`=0 for b<16 or 1 otherwise, and `endIndex`=(b div 2) mod 8. Half-transfer bits never make it valid.
- R9: `busRdData` shows the enable register when `busAddr`=0 and the pending register when `busAddr`=1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 = enable register, 1 = pending register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed register |
| normHalf | input | 8 | Half-transfer event pulses, normal channels |
| normEnd | input | 8 | End-of-transfer event pulses, normal channels |
| dedHalf | input | 8 | Half-transfer event pulses, dedicated channels |
| dedEnd | input | 8 | End-of-transfer event pulses, dedicated channels |
| irqOut | output | 1 | Registered interrupt level |
| endValid | output | 1 | Some end-of-transfer bit is pending |
| endGroup | output | 1 | Group of the selected end event (1 = dedicated) |
| endIndex | output | 3 | Channel index of the selected end event |

## Verification
A channel event and a software write-one-to-clear of the same pending bit can fall in the same clock cycle. The bench drives a dedicated half-transfer pulse and a bus write that clears that exact bit in one cycle. It then reads the pending register and expects the bit still set. A second scenario starts from a set bit and sends the clear with no event, to confirm that the clear path itself works.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  // Strobes issued by the bus decoder to the status datapath
  typedef struct packed {
    logic enLoad;     // replace enable register with write data
    logic pendClear;  // clear pending bits where write data is one
  } regStrobe_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic       busAddr,
  output regStrobe_t strb,
  output logic       rdSelPend
);
  always_comb begin
    strb.enLoad    = busWrEn && !busAddr;
    strb.pendClear = busWrEn && busAddr;
  end

  assign rdSelPend = busAddr;

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enLoad, strb.pendClear}));
endmodule

// File: rtl/dma_irq_core.sv
module dma_irq_core
  import dma_irq_pkg::*;
#(
  parameter int CH_PER_GROUP = 8,
  localparam int STAT_W = 4 * CH_PER_GROUP,
  localparam int IDX_W  = (CH_PER_GROUP > 1) ? $clog2(CH_PER_GROUP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [STAT_W-1:0] wrData,
  input  logic [STAT_W-1:0] evVec,
  input  logic              rdSelPend,
  output logic [STAT_W-1:0] rdData,
  output logic              irqOut,
  output logic              endValid,
  output logic              endGroup,
  output logic [IDX_W-1:0]  endIndex
);
  localparam int NUM_CH = 2 * CH_PER_GROUP;

  logic [STAT_W-1:0] pendQ;
  logic [STAT_W-1:0] enQ;
  logic [STAT_W-1:0] clrMask;

  assign clrMask = strb.pendClear ? wrData : '0;

  // Pending: a new event wins over a clear of the same bit
  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrMask) | evVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            enQ <= '0;
    else if (strb.enLoad) enQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(pendQ & enQ);
  end

  assign rdData = rdSelPend ? pendQ : enQ;

  // Lowest-numbered pending end-of-transfer bit (odd positions only)
  always_comb begin
    endValid = 1'b0;
    endGroup = 1'b0;
    endIndex = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pendQ[2*i+1]) begin
        endValid = 1'b1;
        endGroup = (i >= CH_PER_GROUP);
        endIndex = IDX_W'(i % CH_PER_GROUP);
      end
    end
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evVec != '0) |=> ((pendQ & $past(evVec)) == $past(evVec)));

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pendClear |=> ((pendQ & $past(wrData & ~evVec)) == '0));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendQ & enQ)) |=> irqOut);

  // R8
  always_comb begin
    if (rstN) begin
      end_valid_chk: assert (endValid == (|(pendQ & {NUM_CH{2'b10}})));
    end
  end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [7:0]  normHalf,
  input  logic [7:0]  normEnd,
  input  logic [7:0]  dedHalf,
  input  logic [7:0]  dedEnd,
  output logic        irqOut,
  output logic        endValid,
  output logic        endGroup,
  output logic [2:0]  endIndex
);
  localparam int CH = 8;

  regStrobe_t  strb;
  logic        rdSelPend;
  logic [31:0] evVec;

  // Each channel owns an adjacent pair: half below end
  for (genvar c = 0; c < CH; c++) begin : g_map
    assign evVec[2*c]            = normHalf[c];
    assign evVec[2*c+1]          = normEnd[c];
    assign evVec[2*CH + 2*c]     = dedHalf[c];
    assign evVec[2*CH + 2*c + 1] = dedEnd[c];
  end

  dma_irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .strb     (strb),
    .rdSelPend(rdSelPend)
  );

  dma_irq_core #(.CH_PER_GROUP(CH)) u_core (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (busWrData),
    .evVec    (evVec),
    .rdSelPend(rdSelPend),
    .rdData   (busRdData),
    .irqOut   (irqOut),
    .endValid (endValid),
    .endGroup (endGroup),
    .endIndex (endIndex)
  );
endmodule

// File: tb/dma_irq_unit_test.sv
module dma_irq_unit_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        busWrEn = 0;
  logic        busAddr = 0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  normHalf = '0, normEnd = '0, dedHalf = '0, dedEnd = '0;
  logic        irqOut, endValid, endGroup;
  logic [2:0]  endIndex;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_irq_unit uut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic a, output logic [31:0] v);
    busAddr = a; #1; v = busRdData;
  endtask

  task automatic wrReg(input logic a, input logic [31:0] d);
    busWrEn = 1; busAddr = a; busWrData = d;
    step();
    busWrEn = 0; busWrData = '0;
  endtask

  task automatic clearAll();
    wrReg(1'b1, 32'hFFFF_FFFF);
    wrReg(1'b0, 32'h0);
    step();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdReg(1'b0, v); check("R1 enable", v, 0);
    rdReg(1'b1, v); check("R1 pending", v, 0);
    check("R1 irq", irqOut, 0);
    check("R1 endValid", endValid, 0);
  endtask

  task automatic t_latch_disabled();
    logic [31:0] v;
    normEnd[3] = 1; step(); normEnd = '0;
    rdReg(1'b1, v); check("R2/R3 normal end ch3 bit7", v, 32'h80);
    step(); step();
    check("R3 irq stays low while disabled", irqOut, 0);
    check("R8 valid", endValid, 1);
    check("R8 group normal", endGroup, 0);
    check("R8 index 3", endIndex, 3);
  endtask

  task automatic t_enable_late();
    logic [31:0] v;
    wrReg(1'b0, 32'h80);
    rdReg(1'b0, v); check("R6 enable readback", v, 32'h80);
    check("R7 irq not yet (registered)", irqOut, 0);
    step();
    check("R7 irq after late enable", irqOut, 1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wrReg(1'b1, 32'h0000_0040);
    rdReg(1'b1, v); check("R4 zero bits untouched", v, 32'h80);
    wrReg(1'b1, 32'h80);
    rdReg(1'b1, v); check("R4 write-one clears", v, 0);
    step();
    check("R7 irq falls after clear", irqOut, 0);
    check("R8 valid gone", endValid, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    dedHalf[2] = 1; step(); dedHalf = '0;
    rdReg(1'b1, v); check("R2 dedicated half ch2 bit20", v, 32'h0010_0000);
    busWrEn = 1; busAddr = 1; busWrData = 32'h0010_0000; dedHalf[2] = 1;
    step();
    busWrEn = 0; busWrData = '0; dedHalf = '0;
    rdReg(1'b1, v); check("R5 set beats clear", v, 32'h0010_0000);
    check("R8 half bit does not set valid", endValid, 0);
    wrReg(1'b1, 32'h0010_0000);
    rdReg(1'b1, v); check("R4 clear without event", v, 0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    dedEnd[0] = 1; normEnd[5] = 1; step(); dedEnd = '0; normEnd = '0;
    rdReg(1'b1, v); check("R2 bits 17 and 11", v, 32'h0002_0800);
    check("R8 lowest picks normal", endGroup, 0);
    check("R8 index 5", endIndex, 5);
    wrReg(1'b1, 32'h800);
    check("R8 then dedicated", endGroup, 1);
    check("R8 dedicated index 0", endIndex, 0);
    dedEnd[7] = 1; step(); dedEnd = '0;
    check("R8 still lowest dedicated", endIndex, 0);
    wrReg(1'b1, 32'h0002_0000);
    check("R8 dedicated index 7", endIndex, 7);
    check("R8 group dedicated", endGroup, 1);
  endtask

  task automatic t_all_and_disable();
    logic [31:0] v;
    wrReg(1'b0, 32'hFFFF_FFFF);
    rdReg(1'b0, v); check("R6 all enabled", v, 32'hFFFF_FFFF);
    step();
    check("R7 irq for dedicated end 7", irqOut, 1);
    wrReg(1'b0, 32'h0);
    step();
    check("R6 write zero disables irq", irqOut, 0);
    normHalf = 8'hFF; dedHalf = 8'h01; step(); normHalf = '0; dedHalf = '0;
    rdReg(1'b1, v); check("R3 several latched", v, 32'h8001_5555);
    wrReg(1'b1, 32'hFFFF_FFFF);
    rdReg(1'b1, v); check("R4 all ones clears all", v, 0);
    rdReg(1'b0, v); check("R9 address 0 selects enable", v, 0);
  endtask

  initial begin
    #200_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    t_reset();
    t_latch_disabled();
    t_enable_late();
    t_w1c();
    clearAll();
    t_collision();
    clearAll();
    t_priority();
    t_all_and_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule